// File: doc/BRIEF.md
# Latency-Programmable Event Pattern Pulser

This block plays back stored test events onto four byte-wide transmit lanes. A host first fills a 36-bit pattern memory through a write port. The memory is split into four equal regions, one for each buffer number. When an accept pulse arrives with a 2-bit buffer number, the block replays the event held in that region. The region's first word is a header that carries the event's output latency. Data words follow, and each one is copied into four lane FIFOs, one byte per lane. A trailer word ends the event. Its 32-bit payload is not transmitted; it is presented as the expected downstream decision.

The FIFO contents are held back until a latency counter, started when the header is read, reaches the header's value. They then drain one entry per clock, with a valid strobe per lane. A data word flagged as a gap produces one idle output cycle in its place. Events are handled one at a time. An accept that arrives before the previous event has fully drained is dropped and recorded in a sticky overrun flag.

Top module: `event_pulser`

## Requirements
- R1: After reset, busy, overrun, fault and all lane valid strobes are low, and lane_data and exp_decision are zero.
- R2: The pattern memory address is {buffer number, 7-bit offset}. An accepted event reads only the region selected by buf_sel at the accept cycle, starting at offset 0.
- R3: Bits 15:0 of the header word give the latency L. A header is a word with bit 35 set. For an event with N data words, the first output beat is registered at clock edge max(N+6, L+5), counting the edge that samples accept as edge 0.
- R4: A plain data word has bits 35:32 clear. Each one is emitted for one cycle, in memory order. Lane i carries word bits 8i+7:8i, and all four valid strobes are high together.
- R5: A word with bit 33 set (gap) yields one output cycle in its position with all valid strobes low and lane_data zero.
- R6: A word with bit 34 set (trailer) ends the copy and is not emitted. Its bits 31:0 appear on exp_decision before busy falls and hold until the next trailer is read.
- R7: busy rises on the cycle after an accepted pulse and falls one cycle after the last output beat. Valid strobes are only high while busy is high.
- R8: An accept that arrives while busy is ignored: it starts no event and changes no output data. It sets the sticky overrun flag, and setting takes priority over ovr_clr. An ovr_clr pulse on its own clears the flag.
- R9: Each lane FIFO holds 64 entries. A data word found while the FIFO is full stops the copy and sets fault. The 64 stored entries are still emitted, and exp_decision keeps its old value.
- R10: If the region's first word lacks bit 35, fault is set, nothing is emitted and busy falls. fault is cleared when the next event is accepted.
- R11: With a latency of zero, or any latency shorter than the copy time, output starts directly after the trailer has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | 9 | Pattern memory write address {buffer, offset} |
| wr_data | input | 36 | Pattern word: control bits 35:32, lane bytes 31:0 |
| accept | input | 1 | Event accept pulse |
| buf_sel | input | 2 | Buffer number sampled with accept |
| ovr_clr | input | 1 | Clears the overrun flag |
| lane_data | output | 32 | Four lane bytes, lane i at bits 8i+7:8i |
| lane_valid | output | 4 | Per-lane transmit strobe |
| busy | output | 1 | An event is being processed |
| overrun | output | 1 | Sticky: an accept was dropped |
| fault | output | 1 | FIFO overflow or missing header on the last event |
| exp_decision | output | 32 | Payload of the last trailer read |

## Verification
The assertions take accept and ovr_clr to be known, single-bit control levels. They also take the host to write only into a region that is not being replayed, so the memory contents cannot change under a running event. The stimulus loads a region only while busy is low, and it never overlaps a write with a replay. Every accept is driven on the falling edge and held for exactly one cycle, so each pulse is sampled at one rising edge. The one deliberate exception is the overrun test, which raises accept during a replay on purpose.

// File: rtl/event_pulser.sv
module event_pulser #(
  parameter int ADDR_W     = 9,
  parameter int FIFO_DEPTH = 64,
  parameter int LAT_W      = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [35:0]       wr_data,
  input  logic              accept,
  input  logic [1:0]        buf_sel,
  input  logic              ovr_clr,
  output logic [31:0]       lane_data,
  output logic [3:0]        lane_valid,
  output logic              busy,
  output logic              overrun,
  output logic              fault,
  output logic [31:0]       exp_decision
);

  localparam int LANES     = 4;
  localparam int OFF_W     = ADDR_W - 2;
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int HDR_B     = 34;
  localparam int TRL_B     = 33;
  localparam int GAP_B     = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_ACCEPT, S_HEADER, S_COPY, S_WAIT, S_DONE, S_OUTPUT
  } state_t;

  state_t            state;
  logic [1:0]        buf_q;
  logic [OFF_W-1:0]  off;
  logic [LAT_W-1:0]  lat_q, lat_cnt;
  logic [34:0]       rd_q;
  logic [35:0]       mem [MEM_WORDS];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  fcount;
  logic              push, pop, full;

  assign busy = (state != S_IDLE);
  assign full = (fcount == CNT_W'(FIFO_DEPTH));
  assign push = (state == S_COPY) && !rd_q[TRL_B] && !full;
  assign pop  = (state == S_OUTPUT) && (fcount != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= {mem[{buf_q, off}][35:33], mem[{buf_q, off}][31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      fcount <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   fcount <= fcount + 1'b1;
        2'b01:   fcount <= fcount - 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [8:0] store [FIFO_DEPTH];
    logic [7:0] q;
    logic       v;

    always_ff @(posedge clk)
      if (push) store[wptr] <= {rd_q[GAP_B], rd_q[8*g +: 8]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (pop && !store[rptr][8]) begin
        q <= store[rptr][7:0];
        v <= 1'b1;
      end else begin
        q <= '0;
        v <= 1'b0;
      end
    end

    assign lane_data[8*g +: 8] = q;
    assign lane_valid[g]       = v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      buf_q        <= '0;
      off          <= '0;
      lat_q        <= '0;
      lat_cnt      <= '0;
      exp_decision <= '0;
      fault        <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      if (accept && state != S_IDLE) overrun <= 1'b1;
      else if (ovr_clr)              overrun <= 1'b0;

      if ((state == S_COPY || state == S_WAIT) && lat_cnt != '1)
        lat_cnt <= lat_cnt + 1'b1;

      case (state)
        S_IDLE: if (accept) begin
          buf_q <= buf_sel;
          off   <= '0;
          fault <= 1'b0;
          state <= S_ACCEPT;
        end
        S_ACCEPT: begin
          off   <= OFF_W'(1);
          state <= S_HEADER;
        end
        S_HEADER: if (!rd_q[HDR_B]) begin
          fault <= 1'b1;
          state <= S_IDLE;
        end else begin
          lat_q   <= rd_q[LAT_W-1:0];
          lat_cnt <= '0;
          off     <= off + 1'b1;
          state   <= S_COPY;
        end
        S_COPY: if (rd_q[TRL_B]) begin
          exp_decision <= rd_q[31:0];
          state        <= S_WAIT;
        end else if (full) begin
          fault <= 1'b1;
          state <= S_WAIT;
        end else begin
          off <= off + 1'b1;
        end
        S_WAIT:   if (lat_cnt >= lat_q) state <= S_DONE;
        S_DONE:   state <= S_OUTPUT;
        S_OUTPUT: if (fcount == '0) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/event_pulser_chk.sv
module event_pulser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        ovr_clr,
  input logic [3:0]  lane_valid,
  input logic        busy,
  input logic        overrun,
  input logic        fault,
  input logic [31:0] exp_decision
);

  // R7
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid != 4'h0 |-> busy);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && busy |=> overrun);

  // R8
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(accept && busy) |=> !overrun);

  // R6
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(exp_decision));

  // R4
  lanes_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid == 4'h0 || lane_valid == 4'hF);

  // R9
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(busy));

endmodule

bind event_pulser event_pulser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .ovr_clr(ovr_clr),
  .lane_valid(lane_valid), .busy(busy), .overrun(overrun),
  .fault(fault), .exp_decision(exp_decision)
);

// File: tb/event_pulser_test.sv
module event_pulser_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [35:0] wr_data = '0;
  logic        accept = 1'b0;
  logic [1:0]  buf_sel = '0;
  logic        ovr_clr = 1'b0;
  logic [31:0] lane_data;
  logic [3:0]  lane_valid;
  logic        busy, overrun, fault;
  logic [31:0] exp_decision;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  event_pulser uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .accept(accept), .buf_sel(buf_sel),
    .ovr_clr(ovr_clr), .lane_data(lane_data), .lane_valid(lane_valid),
    .busy(busy), .overrun(overrun), .fault(fault),
    .exp_decision(exp_decision)
  );

  // {buf[41:40], latency[39:24], n_words[23:16], gap_index[15:8], seed[7:0]}
  localparam logic [41:0] VEC [5] = '{
    {2'd0, 16'd0,  8'd4, 8'd255, 8'd10},
    {2'd1, 16'd30, 8'd3, 8'd1,   8'd40},
    {2'd2, 16'd8,  8'd6, 8'd3,   8'd90},
    {2'd3, 16'd7,  8'd2, 8'd255, 8'd200},
    {2'd0, 16'd6,  8'd5, 8'd4,   8'd3}
  };

  function automatic logic [31:0] pat(input logic [7:0] seed, input int k);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = seed + 8'(4*k + i);
    return r;
  endfunction

  function automatic logic [31:0] dec(input logic [7:0] seed);
    return {seed, 8'hD0, ~seed, 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [35:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_event(input logic [1:0] b, input logic [15:0] lat,
                            input int n, input int gap, input logic [7:0] seed);
    wr({b, 7'd0}, {4'b1000, 16'h0, lat});
    for (int k = 1; k <= n; k++)
      wr({b, 7'(k)}, {(k - 1 == gap) ? 4'b0010 : 4'b0000, pat(seed, k - 1)});
    wr({b, 7'(n + 1)}, {4'b0100, dec(seed)});
  endtask

  task automatic run_event(input logic [1:0] b, input int lat, input int n,
                           input int gap, input logic [7:0] seed, input bit intrude);
    int cyc = 0;
    bit found = 0;
    int k = (n + 6 > lat + 5) ? n + 6 : lat + 5;
    @(negedge clk);
    accept = 1'b1; buf_sel = b;
    while (!found && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (intrude && cyc == 3) begin
        accept = 1'b1; buf_sel = 2'd2; ovr_clr = 1'b1;
      end else begin
        accept = 1'b0; ovr_clr = 1'b0;
      end
      if (intrude && cyc == 4)
        chk(overrun == 1'b1, "R8 overrun set over clear", 64'(overrun), 64'd1);
      if (lane_valid != 4'h0) found = 1;
    end
    // R3 R11: first beat registered at edge k, seen after k+1 rising edges
    chk(cyc == k + 1, "R3 first beat timing", 64'(cyc), 64'(k + 1));
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      if (j == gap)
        chk(lane_valid == 4'h0 && lane_data == 32'h0, "R5 gap beat",
            64'({lane_valid, lane_data}), 64'h0);
      else
        chk(lane_valid == 4'hF && lane_data == pat(seed, j), "R4 data beat",
            64'({lane_valid, lane_data}), {28'h0, 4'hF, pat(seed, j)});
      chk(busy == 1'b1, "R7 busy during output", 64'(busy), 64'd1);
    end
    @(negedge clk);
    chk(busy == 1'b0 && lane_valid == 4'h0, "R7 busy falls after last beat",
        64'({busy, lane_valid}), 64'h0);
    chk(exp_decision == dec(seed), "R6 trailer payload", 64'(exp_decision), 64'(dec(seed)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int beats;
    logic [31:0] last, old_dec;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && overrun == 0 && fault == 0 && lane_valid == 0,
        "R1 reset flags", 64'({busy, overrun, fault, lane_valid}), 64'h0);
    chk(lane_data == 0 && exp_decision == 0, "R1 reset data",
        {lane_data, exp_decision}, 64'h0);
    rst_n = 1'b1;

    // R2: all four regions loaded before any replay
    for (int v = 0; v < 4; v++)
      load_event(VEC[v][41:40], VEC[v][39:24], int'(VEC[v][23:16]),
                 int'(VEC[v][15:8]), VEC[v][7:0]);
    for (int v = 0; v < 5; v++) begin
      if (v == 4)
        load_event(VEC[v][41:40], VEC[v][39:24], int'(VEC[v][23:16]),
                   int'(VEC[v][15:8]), VEC[v][7:0]);
      run_event(VEC[v][41:40], int'(VEC[v][39:24]), int'(VEC[v][23:16]),
                int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);
    end

    // R8: accept while busy is ignored
    load_event(2'd1, 16'd20, 2, 255, 8'd77);
    run_event(2'd1, 20, 2, 255, 8'd77, 1'b1);
    beats = 0;
    repeat (12) begin
      @(negedge clk);
      if (busy || lane_valid != 0) beats++;
    end
    chk(beats == 0, "R8 ignored accept starts nothing", 64'(beats), 64'd0);
    chk(overrun == 1'b1, "R8 overrun sticky", 64'(overrun), 64'd1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R8 overrun cleared", 64'(overrun), 64'd0);

    // R10: missing header
    wr({2'd3, 7'd0}, {4'b0000, 32'h1234_5678});
    @(negedge clk);
    accept = 1'b1; buf_sel = 2'd3;
    @(negedge clk);
    accept = 1'b0;
    beats = 0;
    repeat (2) begin
      @(negedge clk);
      if (lane_valid != 0) beats++;
    end
    chk(busy == 1'b0 && fault == 1'b1, "R10 bad header aborts",
        64'({busy, fault}), 64'h1);
    repeat (6) begin
      @(negedge clk);
      if (lane_valid != 0) beats++;
    end
    chk(beats == 0, "R10 no output on bad header", 64'(beats), 64'd0);

    // R9: 65 data words overflow the 64-entry FIFOs
    old_dec = exp_decision;
    wr({2'd0, 7'd0}, {4'b1000, 32'h0});
    for (int k = 1; k <= 65; k++) wr({2'd0, 7'(k)}, {4'b0000, pat(8'd1, k - 1)});
    wr({2'd0, 7'd66}, {4'b0100, 32'hCAFE_F00D});
    @(negedge clk);
    accept = 1'b1; buf_sel = 2'd0;
    @(negedge clk);
    accept = 1'b0;
    chk(fault == 1'b0, "R10 fault cleared on accept", 64'(fault), 64'd0);
    beats = 0;
    last = '0;
    for (int c = 0; c < 400 && busy; c++) begin
      @(negedge clk);
      if (lane_valid == 4'hF) begin beats++; last = lane_data; end
    end
    chk(beats == 64, "R9 beats after overflow", 64'(beats), 64'd64);
    chk(last == pat(8'd1, 63), "R9 last stored word", 64'(last), 64'(pat(8'd1, 63)));
    chk(fault == 1'b1, "R9 overflow fault", 64'(fault), 64'd1);
    chk(exp_decision == old_dec, "R9 decision unchanged", 64'(exp_decision), 64'(old_dec));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule